// File: doc/BRIEF.md
# Gated IF Frequency Window Checker

This block decides whether an intermediate-frequency signal sits close enough to its nominal value to count as a tuned station. A programmable sampling timer, clocked by the oscillator (system) clock, opens a gate for a chosen number of oscillator cycles. While the gate is open, a 21-bit down counter is decremented once for every rising edge of the IF signal. Before the gate opens, the counter is loaded with the number of edges a correctly tuned IF would produce in that gate.

When the gate closes, the final counter state is classified. The count wraps modulo 2^21. A state at or just above zero, or at or just below all-ones, means the edge count matched the expectation within a programmable tolerance, and the pass flag is raised. Otherwise the pass flag is cleared. Measurements repeat back to back while both the measurement enable and the PLL lock input are high. The station-detect output is the pass flag ANDed with an external field-strength-above-threshold bit.

The IF signal is asynchronous to the system clock. It passes through a synchronizer, and only its rising edges are counted. The gate base tick is set by the timer value: software programs it so that the tick is 160 us in FM mode or 1 ms in AM mode.

Top module: `ifc_freq_window_check`

## Requirements
- R1: After synchronous reset, `pass_o` and `station_o` are 0.
- R2: A measurement starts only in a cycle where `meas_en_i` and `pll_lock_i` are both 1. While both stay 1, a new measurement starts one cycle after each result is taken, using the settings present at that start.
- R3: The gate stays open for exactly (`timer_val_i` + 1) * 2^`win_sel_i` oscillator cycles. `timer_val_i` and `win_sel_i` are sampled at the start of the measurement.
- R4: At the start, the counter loads (`trim_i` + 1697) * 2^`win_sel_i` when `am_mode_i` = 0 (FM). It loads (`trim_i` + 448) * 2^`win_sel_i` when `am_mode_i` = 1 (AM).
- R5: Each rising edge of `if_clk_i` seen while the gate is open decrements the counter by one, modulo 2^21, after a two-stage synchronizer.
- R6: With tolerance T = 2^`tol_sel_i`, the result passes when the final state S satisfies S <= T or S >= 2^21 - 1 - T. In edge terms, M edges against an expected N pass when N - T <= M <= N + T + 1.
- R7: `pass_o` changes only two cycles after the last gate cycle of a completed measurement. At all other times it holds its value.
- R8: If `meas_en_i` or `pll_lock_i` goes low while the gate is open, the measurement is abandoned. `pass_o` keeps its previous value.
- R9: `station_o` equals `pass_o` AND `field_ok_i`, registered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator / system clock |
| rst | input | 1 | Synchronous active-high reset |
| if_clk_i | input | 1 | IF signal, asynchronous, rising edges counted |
| am_mode_i | input | 1 | 0 = FM nominal count, 1 = AM nominal count |
| timer_val_i | input | 14 | Gate base tick length minus one, in oscillator cycles |
| win_sel_i | input | 3 | Gate length = base tick * 2^value |
| trim_i | input | 5 | Center trim added to the nominal count |
| tol_sel_i | input | 3 | Tolerance = 2^value counter LSBs |
| meas_en_i | input | 1 | Software measurement enable |
| pll_lock_i | input | 1 | PLL lock indication |
| field_ok_i | input | 1 | Field strength above threshold |
| pass_o | output | 1 | Last completed measurement was within the window |
| station_o | output | 1 | Registered pass AND field strength |

## Verification
The bench drives the IF with a fixed period and sets the gate to an exact multiple of that period, so every edge count is known. It then moves the trim so that the final state lands exactly on each edge of the tolerance band, on both the zero side and the all-ones side. A comparison that is off by one, or that misses the wraparound side, flips one of these verdicts. Doubled windows in both modes expose a load value that fails to scale the trim or the base with the window. Dropping lock or enable in mid-gate, and changing the trim while measurements run back to back, catch a design that publishes aborted results, fails to restart, or samples its settings at the wrong time.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int DEF_CNT_W   = 21;
  localparam int DEF_TIMER_W = 14;
  localparam int DEF_SEL_W   = 3;
  localparam int DEF_TRIM_W  = 5;
  localparam int DEF_TOL_W   = 3;
  localparam int DEF_FM_BASE = 1697;
  localparam int DEF_AM_BASE = 448;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_JUDGE = 2'd2
  } meas_st_e;
endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
  parameter int TIMER_W = 14,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               run_i,
  input  logic [TIMER_W-1:0] period_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               last_o
);
  localparam int TICK_W = (1 << SEL_W) - 1;

  logic [TIMER_W-1:0] per_q, pre_q;
  logic [SEL_W-1:0]   sel_q;
  logic [TICK_W-1:0]  tick_q, tick_last;
  logic [TICK_W:0]    tick_span;
  logic               pre_wrap;

  assign tick_span = ({{TICK_W{1'b0}}, 1'b1} << sel_q) - 1'b1;
  assign tick_last = tick_span[TICK_W-1:0];
  assign pre_wrap  = (pre_q == per_q);
  assign last_o    = run_i && pre_wrap && (tick_q == tick_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= '0;
      sel_q  <= '0;
      pre_q  <= '0;
      tick_q <= '0;
    end else if (start_i) begin
      per_q  <= period_i;
      sel_q  <= sel_i;
      pre_q  <= '0;
      tick_q <= '0;
    end else if (run_i) begin
      if (pre_wrap) begin
        pre_q  <= '0;
        tick_q <= tick_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R3
  tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (pre_q <= per_q) && (tick_q <= tick_last));
endmodule

// File: rtl/ifc_down_counter.sv
module ifc_down_counter #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ifc_window_judge.sv
module ifc_window_judge #(
  parameter int W     = 21,
  parameter int TOL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             judge_i,
  input  logic [W-1:0]     cnt_i,
  input  logic [TOL_W-1:0] tol_sel_i,
  output logic             pass_o
);
  logic [W-1:0] tol, hi_floor;
  logic         near_zero, near_ones, pass_q;

  assign tol       = {{(W-1){1'b0}}, 1'b1} << tol_sel_i;
  assign hi_floor  = {W{1'b1}} - tol;
  assign near_zero = (cnt_i <= tol);
  assign near_ones = (cnt_i >= hi_floor);

  always_ff @(posedge clk) begin
    if (rst)          pass_q <= 1'b0;
    else if (judge_i) pass_q <= near_zero | near_ones;
  end

  assign pass_o = pass_q;

  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !judge_i |=> $stable(pass_q));
endmodule

// File: rtl/ifc_freq_window_check.sv
module ifc_freq_window_check
  import ifc_pkg::*;
#(
  parameter int CNT_W       = DEF_CNT_W,
  parameter int TIMER_W     = DEF_TIMER_W,
  parameter int SEL_W       = DEF_SEL_W,
  parameter int TRIM_W      = DEF_TRIM_W,
  parameter int TOL_W       = DEF_TOL_W,
  parameter int SYNC_STAGES = 2,
  parameter int FM_BASE     = DEF_FM_BASE,
  parameter int AM_BASE     = DEF_AM_BASE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               if_clk_i,
  input  logic               am_mode_i,
  input  logic [TIMER_W-1:0] timer_val_i,
  input  logic [SEL_W-1:0]   win_sel_i,
  input  logic [TRIM_W-1:0]  trim_i,
  input  logic [TOL_W-1:0]   tol_sel_i,
  input  logic               meas_en_i,
  input  logic               pll_lock_i,
  input  logic               field_ok_i,
  output logic               pass_o,
  output logic               station_o
);
  localparam int LEN_W = TIMER_W + (1 << SEL_W);

  meas_st_e      st_q;
  logic          go, start, run, judge, gate_last, if_rise;
  logic [CNT_W-1:0] base_cnt, exp_cnt, cnt;
  logic          pass, station_q;

  assign go    = meas_en_i && pll_lock_i;
  assign start = (st_q == ST_IDLE) && go;
  assign run   = (st_q == ST_RUN);
  assign judge = (st_q == ST_JUDGE);

  assign base_cnt = am_mode_i ? CNT_W'(AM_BASE) : CNT_W'(FM_BASE);
  assign exp_cnt  = (base_cnt + CNT_W'(trim_i)) << win_sel_i;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (go) st_q <= ST_RUN;
        ST_RUN:   if (!go) st_q <= ST_IDLE;
                  else if (gate_last) st_q <= ST_JUDGE;
        ST_JUDGE: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  ifc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .async_i(if_clk_i), .rise_o(if_rise)
  );

  ifc_gate_timer #(.TIMER_W(TIMER_W), .SEL_W(SEL_W)) i_timer (
    .clk(clk), .rst(rst), .start_i(start), .run_i(run),
    .period_i(timer_val_i), .sel_i(win_sel_i), .last_o(gate_last)
  );

  ifc_down_counter #(.W(CNT_W)) i_count (
    .clk(clk), .rst(rst), .load_i(start), .load_val_i(exp_cnt),
    .dec_i(run && if_rise), .cnt_o(cnt)
  );

  ifc_window_judge #(.W(CNT_W), .TOL_W(TOL_W)) i_judge (
    .clk(clk), .rst(rst), .judge_i(judge), .cnt_i(cnt),
    .tol_sel_i(tol_sel_i), .pass_o(pass)
  );

  always_ff @(posedge clk) begin
    if (rst) station_q <= 1'b0;
    else     station_q <= pass && field_ok_i;
  end

  assign pass_o    = pass;
  assign station_o = station_q;

  // Gate-length checker state
  logic [TIMER_W-1:0] chk_irc_q;
  logic [SEL_W-1:0]   chk_sel_q;
  logic [LEN_W-1:0]   gate_len_q, exp_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_irc_q  <= '0;
      chk_sel_q  <= '0;
      gate_len_q <= '0;
    end else if (start) begin
      chk_irc_q  <= timer_val_i;
      chk_sel_q  <= win_sel_i;
      gate_len_q <= LEN_W'(1);
    end else if (run) begin
      gate_len_q <= gate_len_q + 1'b1;
    end
  end

  assign exp_len = (LEN_W'(chk_irc_q) + LEN_W'(1)) << chk_sel_q;

  // R3
  gate_len_chk: assert property (@(posedge clk) disable iff (rst)
    gate_last |-> gate_len_q == exp_len);

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(st_q) == ST_IDLE) |-> $past(meas_en_i && pll_lock_i));

  // R4
  load_val_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(st_q) == ST_IDLE) |-> cnt == $past(exp_cnt));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !go) |=> (st_q == ST_IDLE) && $stable(pass));

  // R9
  station_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(station_o) |-> $past(field_ok_i));
endmodule

// File: tb/test_ifc_freq_window_check.sv
module test_ifc_freq_window_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        if_clk = 1'b0;
  logic        am_mode = 1'b0;
  logic [13:0] timer_val = '0;
  logic [2:0]  win_sel = '0;
  logic [4:0]  trim = '0;
  logic [2:0]  tol_sel = '0;
  logic        meas_en = 1'b0;
  logic        pll_lock = 1'b0;
  logic        field_ok = 1'b0;
  logic        pass, station;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int if_per = 4;
  int ph = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ifc_freq_window_check i_ifc_freq_window_check (
    .clk(clk), .rst(rst), .if_clk_i(if_clk), .am_mode_i(am_mode),
    .timer_val_i(timer_val), .win_sel_i(win_sel), .trim_i(trim),
    .tol_sel_i(tol_sel), .meas_en_i(meas_en), .pll_lock_i(pll_lock),
    .field_ok_i(field_ok), .pass_o(pass), .station_o(station)
  );

  // IF generator: period of if_per clock cycles, changes on falling edges
  always @(negedge clk) begin
    ph = (ph + 1 >= if_per) ? 0 : ph + 1;
    if_clk <= (ph < if_per / 2);
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic measure(input bit am, input int cf, input int sel,
                         input int irc, input int ew);
    int g;
    meas_en = 1'b0;
    repeat (4) @(negedge clk);
    am_mode   = am;
    trim      = cf[4:0];
    win_sel   = sel[2:0];
    timer_val = irc[13:0];
    tol_sel   = ew[2:0];
    repeat (6) @(negedge clk);
    meas_en = 1'b1;
    g = (irc + 1) << sel;
    repeat (g + 20) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 pass after reset", pass, 1'b0);
    check("R1 station after reset", station, 1'b0);
  endtask

  // FM nominal: N = 1712, 6848 cycles / 4 = 1712 edges
  task automatic t_nominal;
    field_ok = 1'b1;
    measure(1'b0, 15, 0, 6847, 0);
    check("R3 R4 R5 nominal FM pass", pass, 1'b1);
    check("R9 station with field ok", station, 1'b1);
    field_ok = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 station without field", station, 1'b0);
    // back-to-back restart picks up new trim (state 10 > tol 1)
    trim = 5'd25;
    repeat (2 * 6848 + 40) @(negedge clk);
    check("R2 continuous restart uses new trim", pass, 1'b0);
  endtask

  // Tolerance 4, edges fixed at 1712
  task automatic t_tol_wide;
    measure(1'b0, 19, 0, 6847, 2);
    check("R6 state 4 tol 4 pass", pass, 1'b1);
    measure(1'b0, 20, 0, 6847, 2);
    check("R6 state 5 tol 4 fail", pass, 1'b0);
    measure(1'b0, 10, 0, 6847, 2);
    check("R6 state all-ones minus 4 pass", pass, 1'b1);
    measure(1'b0, 9, 0, 6847, 2);
    check("R6 state all-ones minus 5 fail", pass, 1'b0);
  endtask

  task automatic t_tol_narrow;
    measure(1'b0, 13, 0, 6847, 0);
    check("R6 state all-ones minus 1 tol 1 pass", pass, 1'b1);
    measure(1'b0, 12, 0, 6847, 0);
    check("R6 state all-ones minus 2 tol 1 fail", pass, 1'b0);
  endtask

  // AM: N = 464, 1856 cycles / 4 = 464 edges
  task automatic t_am;
    measure(1'b1, 16, 0, 1855, 0);
    check("R4 AM nominal pass", pass, 1'b1);
    measure(1'b0, 16, 0, 1855, 0);
    check("R4 FM base on AM gate fails", pass, 1'b0);
  endtask

  task automatic t_windows;
    measure(1'b0, 15, 1, 6847, 0);
    check("R3 R4 FM doubled window pass", pass, 1'b1);
    measure(1'b1, 0, 2, 1791, 0);
    check("R3 R4 AM window x4 pass", pass, 1'b1);
    measure(1'b1, 2, 2, 1791, 0);
    check("R4 trim scaled by window fails", pass, 1'b0);
  endtask

  task automatic t_lock_hold;
    measure(1'b0, 15, 0, 6847, 0);
    pll_lock = 1'b0;
    trim = 5'd25;
    repeat (8000) @(negedge clk);
    check("R2 R7 no update without lock", pass, 1'b1);
    pll_lock = 1'b1;
    repeat (6848 + 20) @(negedge clk);
    check("R2 measurement after relock", pass, 1'b0);
  endtask

  task automatic t_abort;
    measure(1'b0, 15, 0, 6847, 0);
    meas_en = 1'b0;
    repeat (4) @(negedge clk);
    trim = 5'd25;
    meas_en = 1'b1;
    repeat (3000) @(negedge clk);
    meas_en = 1'b0;
    repeat (6000) @(negedge clk);
    check("R8 aborted gate keeps pass", pass, 1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    pll_lock = 1'b1;
    t_nominal();
    t_tol_wide();
    t_tol_narrow();
    t_am();
    t_windows();
    t_lock_hold();
    t_abort();
    done = 1'b1;
  end

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (done || cycles >= 195000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule